// File: doc/BRIEF.md
# Byte-to-Bit-Plane Stream Transposer

This block accepts a whole block of text characters in one cycle and turns it into eight bit planes. Plane i gathers bit i of every byte, and bit j of each plane belongs to character j of the block. The first character in text order lands at the lowest bit of every plane, so reading a plane from bit 0 upward follows the text.

From the planes alone, fixed bitwise logic builds three character-class streams. Each stream has a 1 at position j exactly when character j is a member of the class. The classes are one single character, a set of two characters, and an inclusive character range. Their members are elaboration parameters and default to `a`, the pair {`z`, `9`} and the digits `0`..`9`.

A pattern matcher downstream uses these streams. It combines marker streams with class streams by AND, OR and addition over the whole block, so it never needs a lookup per byte. The planes and the class streams are registered together. A one-cycle valid pulse marks each block that has been taken in.

Top module: `bit_plane_xpose`

## Requirements
- R1: After reset, `out_valid` is 0 and every bit of `basis_out`, `cls_single`, `cls_pair` and `cls_range` is 0.
- R2: Byte j of a block is `in_block[8*j+7:8*j]`. Plane i sits at `basis_out[i*BLOCK_BYTES +: BLOCK_BYTES]`, and bit j of plane i equals bit i of byte j.
- R3: Byte 0, the first character in text order, maps to bit 0 of every plane and of every class stream.
- R4: When no byte of an accepted block has bit 7 set, plane 7 of that block is all zero.
- R5: Bit j of `cls_single` is 1 exactly when byte j equals SINGLE_CH (default 8'h61). Bytes that differ only in bit 7, such as 8'hE1, do not match.
- R6: Bit j of `cls_pair` is 1 exactly when byte j equals PAIR_CH0 (default 8'h7A) or PAIR_CH1 (default 8'h39).
- R7: Bit j of `cls_range` is 1 exactly when byte j lies in DIGIT_LO..DIGIT_HI inclusive (default 8'h30..8'h39). 8'h2F, 8'h3A and 8'hB0..8'hB9 are outside the range.
- R8: A block presented with `in_valid`=1 at a rising clock edge appears on every data output right after that edge. `out_valid` is 1 for the cycle that follows each accepted block, so back-to-back blocks keep it high.
- R9: A clock edge with `in_valid`=0 leaves all data outputs unchanged and drives `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Load strobe for `in_block` |
| in_block | input | 8*BLOCK_BYTES | Block of bytes, byte j at bits 8j+7..8j |
| out_valid | output | 1 | One-cycle pulse per accepted block |
| basis_out | output | 8*BLOCK_BYTES | Eight registered planes, plane i at bits i*BLOCK_BYTES and up |
| cls_single | output | BLOCK_BYTES | Single-character class stream |
| cls_pair | output | BLOCK_BYTES | Two-character class stream |
| cls_range | output | BLOCK_BYTES | Range class stream |

## Verification
The bench puts the bytes on each side of the range edges into single blocks: 8'h2F, 8'h30, 8'h39 and 8'h3A. A range compare that is off by one would then flag a neighbour or drop an end digit. It also sends bytes that equal a class member in their low seven bits but have bit 7 set. Logic that ignored plane 7 would report false members for those. Back-to-back blocks and idle gaps are mixed in, which exposes a valid pulse that stretches or gets lost and a register that reloads without a strobe. Lopsided blocks catch a transposer that reverses text order or swaps planes, because each plane bit is compared with the byte it came from.

// File: rtl/bpx_pkg.sv
package bpx_pkg;
  localparam int PLANES = 8;

  typedef logic [PLANES-1:0] char_t;

  function automatic logic char_in_span(char_t c, char_t lo, char_t hi);
    return (c >= lo) && (c <= hi);
  endfunction
endpackage

// File: rtl/bpx_rst_sync.sv
module bpx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bpx_transpose.sv
module bpx_transpose
  import bpx_pkg::*;
#(
  parameter int BLOCK_BYTES = 128
) (
  input  logic [PLANES*BLOCK_BYTES-1:0] blk,
  output logic [PLANES*BLOCK_BYTES-1:0] planes
);
  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    for (genvar j = 0; j < BLOCK_BYTES; j++) begin : g_pos
      assign planes[p*BLOCK_BYTES + j] = blk[j*PLANES + p];
    end
  end
endmodule

// File: rtl/bpx_class.sv
module bpx_class
  import bpx_pkg::*;
#(
  parameter int          BLOCK_BYTES = 128,
  parameter logic [7:0]  SINGLE_CH   = 8'h61,
  parameter logic [7:0]  PAIR_CH0    = 8'h7A,
  parameter logic [7:0]  PAIR_CH1    = 8'h39,
  parameter logic [7:0]  DIGIT_LO    = 8'h30,
  parameter logic [7:0]  DIGIT_HI    = 8'h39
) (
  input  logic [PLANES*BLOCK_BYTES-1:0] planes,
  output logic [BLOCK_BYTES-1:0]        hit_single,
  output logic [BLOCK_BYTES-1:0]        hit_pair,
  output logic [BLOCK_BYTES-1:0]        hit_range
);
  for (genvar j = 0; j < BLOCK_BYTES; j++) begin : g_pos
    char_t rebuilt;
    for (genvar p = 0; p < PLANES; p++) begin : g_bit
      assign rebuilt[p] = planes[p*BLOCK_BYTES + j];
    end
    assign hit_single[j] = (rebuilt == SINGLE_CH);
    assign hit_pair[j]   = (rebuilt == PAIR_CH0) || (rebuilt == PAIR_CH1);
    assign hit_range[j]  = char_in_span(rebuilt, DIGIT_LO, DIGIT_HI);
  end
endmodule

// File: rtl/bpx_stage.sv
module bpx_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          vld_q
);
  logic [DW-1:0] q_next;
  logic          vld_next;

  always_comb begin
    q_next   = q;
    vld_next = load;
    if (load) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      vld_q <= 1'b0;
    end else begin
      q     <= q_next;
      vld_q <= vld_next;
    end
  end
endmodule

// File: rtl/bit_plane_xpose.sv
module bit_plane_xpose
  import bpx_pkg::*;
#(
  parameter int          BLOCK_BYTES = 128,
  parameter logic [7:0]  SINGLE_CH   = 8'h61,
  parameter logic [7:0]  PAIR_CH0    = 8'h7A,
  parameter logic [7:0]  PAIR_CH1    = 8'h39,
  parameter logic [7:0]  DIGIT_LO    = 8'h30,
  parameter logic [7:0]  DIGIT_HI    = 8'h39
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [PLANES*BLOCK_BYTES-1:0] in_block,
  output logic                          out_valid,
  output logic [PLANES*BLOCK_BYTES-1:0] basis_out,
  output logic [BLOCK_BYTES-1:0]        cls_single,
  output logic [BLOCK_BYTES-1:0]        cls_pair,
  output logic [BLOCK_BYTES-1:0]        cls_range
);
  localparam int BW = PLANES*BLOCK_BYTES;
  localparam int DW = BW + 3*BLOCK_BYTES;
  localparam bit SINGLE_OUTSIDE = !((SINGLE_CH >= DIGIT_LO) && (SINGLE_CH <= DIGIT_HI));

  logic                   rst_n_sync;
  logic [BW-1:0]          planes_c;
  logic [BLOCK_BYTES-1:0] single_c, pair_c, range_c;
  logic [DW-1:0]          stage_q;
  logic                   top_bit_any;

  bpx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  bpx_transpose #(.BLOCK_BYTES(BLOCK_BYTES)) u_xpose (
    .blk    (in_block),
    .planes (planes_c)
  );

  bpx_class #(
    .BLOCK_BYTES (BLOCK_BYTES),
    .SINGLE_CH   (SINGLE_CH),
    .PAIR_CH0    (PAIR_CH0),
    .PAIR_CH1    (PAIR_CH1),
    .DIGIT_LO    (DIGIT_LO),
    .DIGIT_HI    (DIGIT_HI)
  ) u_class (
    .planes     (planes_c),
    .hit_single (single_c),
    .hit_pair   (pair_c),
    .hit_range  (range_c)
  );

  bpx_stage #(.DW(DW)) u_stage (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load  (in_valid),
    .d     ({range_c, pair_c, single_c, planes_c}),
    .q     (stage_q),
    .vld_q (out_valid)
  );

  assign basis_out  = stage_q[BW-1:0];
  assign cls_single = stage_q[BW +: BLOCK_BYTES];
  assign cls_pair   = stage_q[BW+BLOCK_BYTES +: BLOCK_BYTES];
  assign cls_range  = stage_q[BW+2*BLOCK_BYTES +: BLOCK_BYTES];

  // High bit of any input byte, taken straight from the byte lanes
  always_comb begin
    top_bit_any = 1'b0;
    for (int j = 0; j < BLOCK_BYTES; j++) top_bit_any |= in_block[j*PLANES + PLANES-1];
  end

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    in_valid |=> out_valid);

  p_idle_drop_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_valid |=> !out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_valid |=> ($stable(basis_out) && $stable(cls_single) &&
                   $stable(cls_pair) && $stable(cls_range)));

  p_plane7_clear_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && !top_bit_any) |=> (basis_out[(PLANES-1)*BLOCK_BYTES +: BLOCK_BYTES] == '0));

  if (SINGLE_OUTSIDE) begin : g_disjoint
    p_single_not_range_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (cls_single & cls_range) == '0);
  end
endmodule

// File: tb/bit_plane_xpose_tb_top.sv
module bit_plane_xpose_tb_top;
  localparam int W  = 128;
  localparam int BW = 8*W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [BW-1:0] in_block = '0;
  logic          out_valid;
  logic [BW-1:0] basis_out;
  logic [W-1:0]  cls_single, cls_pair, cls_range;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  bit_plane_xpose #(.BLOCK_BYTES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
    .out_valid(out_valid), .basis_out(basis_out),
    .cls_single(cls_single), .cls_pair(cls_pair), .cls_range(cls_range)
  );

  function automatic logic [BW-1:0] exp_basis(input logic [BW-1:0] b);
    logic [BW-1:0] r;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < W; j++) r[i*W + j] = b[8*j + i];
    return r;
  endfunction

  // kind 0: single 'a', 1: pair {z,9}, 2: digits
  function automatic logic [W-1:0] exp_cls(input logic [BW-1:0] b, input int kind);
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) begin
      logic [7:0] c;
      c = b[8*j +: 8];
      case (kind)
        0:       r[j] = (c == 8'h61);
        1:       r[j] = (c == 8'h7A) || (c == 8'h39);
        default: r[j] = (c >= 8'h30) && (c <= 8'h39);
      endcase
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_block(input logic [BW-1:0] b, input string tag);
    check(out_valid === 1'b1, {"R8 valid ", tag}, BW'(out_valid), BW'(1));
    check(basis_out === exp_basis(b), {"R2 basis ", tag}, basis_out, exp_basis(b));
    check(cls_single === exp_cls(b, 0), {"R5 single ", tag}, BW'(cls_single), BW'(exp_cls(b, 0)));
    check(cls_pair === exp_cls(b, 1), {"R6 pair ", tag}, BW'(cls_pair), BW'(exp_cls(b, 1)));
    check(cls_range === exp_cls(b, 2), {"R7 range ", tag}, BW'(cls_range), BW'(exp_cls(b, 2)));
  endtask

  // Drive at a falling edge; outputs are checked at the next falling edge
  task automatic send(input logic [BW-1:0] b, input bit keep_valid, input string tag);
    in_valid = 1'b1;
    in_block = b;
    @(negedge clk);
    check_block(b, tag);
    if (!keep_valid) begin
      in_valid = 1'b0;
      in_block = ~b;
      @(negedge clk);
      check(out_valid === 1'b0, {"R9 drop ", tag}, BW'(out_valid), BW'(0));
      check(basis_out === exp_basis(b) && cls_range === exp_cls(b, 2),
            {"R9 hold ", tag}, basis_out, exp_basis(b));
    end
  endtask

  function automatic logic [BW-1:0] rand_block(input bit printable);
    logic [BW-1:0] r;
    for (int j = 0; j < W; j++) begin
      logic [7:0] c;
      if (printable)            c = 8'(8'h20 + ($urandom % 95));
      else if ($urandom % 2)    c = 8'(8'h28 + ($urandom % 88));
      else                      c = 8'($urandom);
      r[8*j +: 8] = c;
    end
    return r;
  endfunction

  initial begin
    #400000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [BW-1:0] b;
    void'($urandom(32'd20140824));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(out_valid === 1'b0, "R1 valid", BW'(out_valid), BW'(0));
    check(basis_out === '0, "R1 basis", basis_out, '0);
    check((cls_single | cls_pair | cls_range) === '0, "R1 classes",
          BW'(cls_single | cls_pair | cls_range), '0);

    // R3: only byte 0 nonzero -> bit 0 of planes and classes
    b = '0;
    b[7:0] = 8'h39;
    send(b, 0, "first");
    check(basis_out[0] && basis_out[3*W] && basis_out[4*W] && basis_out[5*W] && !basis_out[1],
          "R3 plane bit0", basis_out, exp_basis(b));
    check(cls_range === W'(1) && cls_pair === W'(1), "R3 class bit0",
          BW'(cls_range), BW'(1));

    // R7/R5/R6 boundaries and high-bit aliases
    b = '0;
    begin
      logic [7:0] edges [16] = '{8'h2F, 8'h30, 8'h39, 8'h3A, 8'h60, 8'h61, 8'h62, 8'h7A,
                                 8'h79, 8'h7B, 8'hE1, 8'hB0, 8'hB9, 8'hFA, 8'h00, 8'hFF};
      for (int j = 0; j < W; j++) b[8*j +: 8] = edges[j % 16];
    end
    send(b, 0, "edges");
    check(cls_range[0] === 1'b0 && cls_range[3] === 1'b0 && cls_range[1] && cls_range[2],
          "R7 range ends", BW'(cls_range[15:0]), BW'(16'h0006));
    check(cls_single[10] === 1'b0 && cls_range[11] === 1'b0 && cls_pair[13] === 1'b0,
          "R5 high-bit alias", BW'({cls_single[10], cls_range[11], cls_pair[13]}), '0);

    // Text sample with ambiguous digit runs
    begin
      string s = "a453z--b3z--az--a12949z--ca22z7--";
      b = {BW{1'b0}};
      for (int j = 0; j < W; j++) b[8*j +: 8] = 8'(s[j % s.len()]);
    end
    send(b, 0, "text");

    // Uniform blocks
    send({BW{1'b1}}, 0, "all ones");
    send({W{8'h61}}, 0, "all a");

    // R4: printable-only blocks keep plane 7 clear
    for (int k = 0; k < 10; k++) begin
      b = rand_block(1);
      send(b, 0, "printable");
      check(basis_out[7*W +: W] === '0, "R4 plane7", BW'(basis_out[7*W +: W]), '0);
    end

    // R8: back-to-back stream then gap
    for (int k = 0; k < 8; k++) begin
      b = rand_block(0);
      send(b, (k != 7), "burst");
    end

    // Random mix with random idle gaps
    for (int k = 0; k < 60; k++) begin
      b = rand_block(0);
      send(b, ($urandom % 3) == 0, "random");
      if (($urandom % 2) == 0) begin
        in_valid = 1'b0;
        repeat (1 + $urandom % 3) @(negedge clk);
        check(out_valid === 1'b0 && basis_out === exp_basis(b), "R9 idle",
              basis_out, exp_basis(b));
      end
    end

    // R1 again: asynchronous reset mid-run clears the outputs
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0 && basis_out === '0 && cls_single === '0, "R1 rereset",
          basis_out, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule